// File: doc/BRIEF.md
# Serial Configuration Memory Emulator

This block stands in for the serial boot memory that a programmable device reads in master serial mode. The device supplies the configuration clock. It watches `chip_en_n_i` (tied to the device's done pin) and `oe_rst_i` (tied to its init pin), and it shifts in one image bit from `d0_o` on each rising clock. The image is a fixed bit array built into the block. Bit k equals the XOR-reduction of `k & IMG_MASK`. The configuration clock is sampled in the system clock domain. A read pointer steps through the image one bit per rising configuration edge.

Two state machines do the work.

The stream machine has three states:
- `ST_HOLD`: the pointer is cleared.
- `ST_SEND`: data is presented and the pointer advances.
- `ST_END`: the image is exhausted.

Its transitions are:
- Any state goes to `ST_HOLD` while the memory is held.
- `ST_HOLD` goes to `ST_SEND` once the hold is released.
- `ST_SEND` goes to `ST_END` when the pointer moves past the last bit.
- `ST_END` stays in `ST_END`.

The program-pulse machine has two states:
- `PL_IDLE`: `cf_o` is high.
- `PL_LOW`: `cf_o` is low.

A rising reconfigure request moves it from `PL_IDLE` to `PL_LOW`. It returns from `PL_LOW` to `PL_IDLE` when its down-counter expires. This yields a high-low-high pulse on `cf_o` that restarts the attached device.

The memory is held while `oe_rst_i` is low or `chip_en_n_i` is high. While held, the pointer is zero, the data pin is released and the cascade output is high. When the image ends, the cascade output goes low to enable a following memory, and the data pin is released.

Top module: `serial_cfg_prom`

## Requirements
- R1: While `oe_rst_i` is 0 or `chip_en_n_i` is 1, `d0_en_o` is 0 and `ceo_n_o` is 1 in the same cycle, and the read pointer is cleared to 0 at the next `clk` edge.
- R2: The bit presented for pointer value k is XOR-reduce(k & IMG_MASK), where the default IMG_MASK is 16'h00B5. Pointer 0 is the first bit.
- R3: `d0_en_o` is 1 only when all of these hold: `cf_o` is 1, `chip_en_n_i` is 0, `oe_rst_i` is 1, and the pointer is below IMG_BITS. When `d0_en_o` is 0, `d0_o` is 0.
- R4: A rising configuration edge is `cfg_clk_i` sampled 1 at a `clk` edge after being sampled 0 at the previous one. Each such edge in `ST_SEND`, while not held and with `cf_o` at 1, advances the pointer by exactly one at that same `clk` edge.
- R5: Configuration edges while held are ignored, so data restarts at bit 0 after release. The first bit is presented from the first `clk` edge after release.
- R6: After IMG_BITS advances, `d0_en_o` is 0 and `ceo_n_o` is 0. Further configuration edges leave it there; the pointer never wraps.
- R7: A 0-to-1 change of `recfg_req_i`, sampled at a `clk` edge, drives `cf_o` low from that edge for exactly CF_LOW_CYC cycles (default 150), then high again.
- R8: Reconfigure requests that arrive while `cf_o` is low are ignored, and no second pulse follows.
- R9: Configuration edges while `cf_o` is low do not move the pointer.
- R10: While `rst_n` is 0, `cf_o` is 1, `ceo_n_o` is 1, `d0_en_o` is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_i | input | 1 | Configuration clock from the device |
| chip_en_n_i | input | 1 | Active-low select, tied to the device's done pin |
| oe_rst_i | input | 1 | Output enable when high, pointer reset when low |
| recfg_req_i | input | 1 | Reconfigure request; its rising edge triggers a program pulse |
| cf_o | output | 1 | Program pulse to the device, normally high |
| ceo_n_o | output | 1 | Cascade enable, active low at end of image |
| d0_o | output | 1 | Serial data bit |
| d0_en_o | output | 1 | Data pin drive enable; 0 means high impedance |

## Verification
The hold inputs act on `d0_en_o` and `ceo_n_o` in the same cycle. The pointer clears at the next `clk` edge, and after release the first bit shows one edge later. A configuration edge changes `d0_o` at the `clk` edge that samples `cfg_clk_i` high. The program pulse starts at the edge that samples the request and lasts CF_LOW_CYC edges. The bench drives every input on the falling edge of `clk` and samples outputs on the falling edge or just after it, so every result is read one full edge after it becomes due. The whole image is swept bit by bit against the arithmetic formula, and the pulse width is counted cycle by cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_SEND = 2'd1,
        ST_END  = 2'd2
    } stream_st_t;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_LOW  = 1'b1
    } pulse_st_t;

endpackage

// File: rtl/scp_edge_detect.sv
module scp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/scp_image_rom.sv
module scp_image_rom #(
    parameter int          IMG_BITS = 64,
    parameter logic [15:0] IMG_MASK = 16'h00B5,
    parameter int          AW       = $clog2(IMG_BITS + 1)
) (
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    localparam int SLOTS = 2 ** AW;

    logic [SLOTS-1:0] image;

    for (genvar k = 0; k < SLOTS; k++) begin : g_bit
        localparam logic [15:0] KV = 16'(k);
        if (k < IMG_BITS) begin : g_live
            assign image[k] = ^(KV & IMG_MASK);
        end else begin : g_pad
            assign image[k] = 1'b0;
        end
    end

    assign bit_o = image[addr_i];
endmodule

// File: rtl/scp_cf_pulser.sv
module scp_cf_pulser
    import scp_pkg::*;
#(
    parameter int CF_LOW_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_rise_i,
    output logic cf_o
);
    localparam int CW = $clog2(CF_LOW_CYC + 1);

    pulse_st_t     st_q, st_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        unique case (st_q)
            PL_IDLE: begin
                if (req_rise_i) begin
                    st_nx  = PL_LOW;
                    cnt_nx = CW'(CF_LOW_CYC - 1);
                end
            end
            PL_LOW: begin
                if (cnt_q == '0) st_nx  = PL_IDLE;
                else             cnt_nx = cnt_q - CW'(1);
            end
            default: st_nx = PL_IDLE;
        endcase
    end

    always_comb begin
        cf_o = (st_q != PL_LOW);
    end
endmodule

// File: rtl/serial_cfg_prom.sv
module serial_cfg_prom
    import scp_pkg::*;
#(
    parameter int          IMG_BITS   = 64,
    parameter logic [15:0] IMG_MASK   = 16'h00B5,
    parameter int          CF_LOW_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_clk_i,
    input  logic chip_en_n_i,
    input  logic oe_rst_i,
    input  logic recfg_req_i,
    output logic cf_o,
    output logic ceo_n_o,
    output logic d0_o,
    output logic d0_en_o
);
    localparam int            AW     = $clog2(IMG_BITS + 1);
    localparam logic [AW-1:0] LAST_A = AW'(IMG_BITS - 1);
    localparam logic [AW-1:0] END_A  = AW'(IMG_BITS);

    stream_st_t    st_q, st_nx;
    logic [AW-1:0] addr_q, addr_nx;
    logic          cclk_rise, req_rise, hold, advance, rom_bit;

    scp_edge_detect u_cclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cfg_clk_i),
        .rise_o (cclk_rise)
    );

    scp_edge_detect u_req_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (recfg_req_i),
        .rise_o (req_rise)
    );

    scp_cf_pulser #(.CF_LOW_CYC(CF_LOW_CYC)) u_pulser (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rise_i (req_rise),
        .cf_o       (cf_o)
    );

    scp_image_rom #(.IMG_BITS(IMG_BITS), .IMG_MASK(IMG_MASK), .AW(AW)) u_rom (
        .addr_i (addr_q),
        .bit_o  (rom_bit)
    );

    assign hold    = ~oe_rst_i | chip_en_n_i;
    assign advance = cclk_rise & cf_o & ~hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HOLD;
            addr_q <= '0;
        end else begin
            st_q   <= st_nx;
            addr_q <= addr_nx;
        end
    end

    always_comb begin
        st_nx   = st_q;
        addr_nx = addr_q;
        if (hold) begin
            st_nx   = ST_HOLD;
            addr_nx = '0;
        end else begin
            unique case (st_q)
                ST_HOLD: st_nx = ST_SEND;
                ST_SEND: begin
                    if (advance) begin
                        if (addr_q == LAST_A) begin
                            st_nx   = ST_END;
                            addr_nx = END_A;
                        end else begin
                            addr_nx = addr_q + AW'(1);
                        end
                    end
                end
                ST_END:  st_nx = ST_END;
                default: st_nx = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        d0_en_o = (st_q == ST_SEND) & ~hold & cf_o;
        d0_o    = d0_en_o & rom_bit;
        ceo_n_o = ~((st_q == ST_END) & ~hold);
    end
endmodule

// File: rtl/scp_sva.sv
module scp_sva #(
    parameter int IMG_BITS = 64,
    parameter int AW       = $clog2(IMG_BITS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en_n_i,
    input logic          oe_rst_i,
    input logic          recfg_req_i,
    input logic          cf_o,
    input logic          ceo_n_o,
    input logic          d0_en_o,
    input logic [AW-1:0] addr
);
    localparam logic [AW-1:0] END_A = AW'(IMG_BITS);

    logic held;
    assign held = ~oe_rst_i | chip_en_n_i;

    a_r1_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (ceo_n_o && !d0_en_o));

    a_r3_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        d0_en_o |-> (cf_o && !chip_en_n_i && oe_rst_i && addr < END_A));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != END_A) |=> (addr == $past(addr) || addr == $past(addr) + AW'(1) || addr == '0));

    a_r5_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (addr == '0));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == END_A && !held) |=> (addr == END_A));

    a_r6_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n_o |-> !d0_en_o);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cf_o) |-> $past(recfg_req_i));

    a_r9_frozen_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !cf_o |=> (addr == $past(addr) || addr == '0));
endmodule

bind serial_cfg_prom scp_sva #(.IMG_BITS(IMG_BITS), .AW(AW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en_n_i (chip_en_n_i),
    .oe_rst_i    (oe_rst_i),
    .recfg_req_i (recfg_req_i),
    .cf_o        (cf_o),
    .ceo_n_o     (ceo_n_o),
    .d0_en_o     (d0_en_o),
    .addr        (addr_q)
);

// File: tb/tb_serial_cfg_prom.sv
`timescale 1ns/1ps
module tb_serial_cfg_prom;
    localparam int          IMG_BITS   = 64;
    localparam logic [15:0] IMG_MASK   = 16'h00B5;
    localparam int          CF_LOW_CYC = 150;

    logic clk = 1'b0;
    logic rst_n, cfg_clk, ce_n, oe_rst, req;
    logic cf, ceo_n, d0, d0_en;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    serial_cfg_prom #(.IMG_BITS(IMG_BITS), .IMG_MASK(IMG_MASK), .CF_LOW_CYC(CF_LOW_CYC)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_clk_i   (cfg_clk),
        .chip_en_n_i (ce_n),
        .oe_rst_i    (oe_rst),
        .recfg_req_i (req),
        .cf_o        (cf),
        .ceo_n_o     (ceo_n),
        .d0_o        (d0),
        .d0_en_o     (d0_en)
    );

    function automatic logic exp_bit(input int k);
        logic [15:0] kv;
        kv = 16'(k);
        return ^(kv & IMG_MASK);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cclk_pulse();
        @(negedge clk) cfg_clk = 1'b1;
        @(negedge clk) cfg_clk = 1'b0;
    endtask

    task automatic expect_bit(input string tag, input int k);
        chk({tag, " enable"}, int'(d0_en), 1);
        chk({tag, " data"}, int'(d0), int'(exp_bit(k)));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_clk = 1'b0; ce_n = 1'b1; oe_rst = 1'b0; req = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 cf", int'(cf), 1);
        chk("R10 ceo", int'(ceo_n), 1);
        chk("R10 d0_en", int'(d0_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still held by ce/oe
        chk("R1 held d0_en", int'(d0_en), 0);
        chk("R1 held ceo", int'(ceo_n), 1);

        // R2 R4: full image sweep
        ce_n = 1'b0; oe_rst = 1'b1;
        @(negedge clk);
        expect_bit("R2 first", 0);
        for (int k = 0; k < IMG_BITS; k++) begin
            cclk_pulse();
            if (k < IMG_BITS - 1) begin
                expect_bit("R4 sweep", k + 1);
                chk("R4 ceo mid", int'(ceo_n), 1);
            end
        end
        chk("R6 end d0_en", int'(d0_en), 0);
        chk("R6 end ceo", int'(ceo_n), 0);
        for (int j = 0; j < 5; j++) cclk_pulse();
        chk("R6 no wrap d0_en", int'(d0_en), 0);
        chk("R6 no wrap ceo", int'(ceo_n), 0);

        // R1 R5: deselect by chip enable, edges ignored
        @(negedge clk) ce_n = 1'b1;
        #1;
        chk("R1 ce deselect ceo", int'(ceo_n), 1);
        chk("R1 ce deselect d0_en", int'(d0_en), 0);
        for (int j = 0; j < 3; j++) cclk_pulse();
        @(negedge clk) ce_n = 1'b0;
        @(negedge clk);
        expect_bit("R5 restart ce", 0);

        for (int j = 0; j < 10; j++) cclk_pulse();
        expect_bit("R4 advance ten", 10);

        // R1 R5: output-enable reset mid-stream
        @(negedge clk) oe_rst = 1'b0;
        #1;
        chk("R1 oe low d0_en", int'(d0_en), 0);
        chk("R1 oe low ceo", int'(ceo_n), 1);
        for (int j = 0; j < 3; j++) cclk_pulse();
        @(negedge clk) oe_rst = 1'b1;
        @(negedge clk);
        expect_bit("R5 restart oe", 0);

        for (int j = 0; j < 5; j++) cclk_pulse();
        expect_bit("R4 advance five", 5);

        // R7 R8 R9 R3: program pulse
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        begin
            int low_cnt;
            low_cnt = 0;
            while (cf == 1'b0 && low_cnt < 1000) begin
                low_cnt++;
                if (low_cnt == 1) chk("R3 cf low d0_en", int'(d0_en), 0);
                if (low_cnt == 2) req = 1'b1;
                if (low_cnt == 4) req = 1'b0;
                if (low_cnt == 10) cfg_clk = 1'b1;
                if (low_cnt == 12) cfg_clk = 1'b0;
                @(negedge clk);
            end
            chk("R7 pulse width", low_cnt, CF_LOW_CYC);
        end
        expect_bit("R9 pointer kept", 5);
        begin
            int relow;
            relow = 0;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (cf == 1'b0) relow++;
            end
            chk("R8 no second pulse", relow, 0);
        end
        cclk_pulse();
        expect_bit("R4 resume", 6);

        // R10: system reset mid-stream
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R10 mid reset d0_en", int'(d0_en), 0);
        chk("R10 mid reset ceo", int'(ceo_n), 1);
        chk("R10 mid reset cf", int'(cf), 1);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        expect_bit("R10 after reset", 0);

        finish_run();
    end
endmodule